// File: doc/BRIEF.md
# Reed-Solomon Error Pattern Applier

This block sits after a Reed-Solomon decoder that works on 12-bit symbols over a flash page. The decoder hands over up to four error locations, each a symbol position with a 12-bit error value. The block folds each value into a byte-wide page buffer. The buffer holds the data bytes first and the spare bytes directly after them, at linear byte addresses. Every pair of symbols spans three bytes, so a symbol touches either the upper part of one byte and the high nibble of the next, or the low nibble of one byte and all of the next.

A caller pulses `start_i` with the entry count and the packed positions and values. The block captures them and screens every live entry. It then walks the entries in order. Each touched byte costs one read cycle on the single-port RAM (one-cycle read latency) and one write-back cycle carrying the old byte XOR the mask. When it finishes it pulses `done_o`, with `count_o` giving the number of applied patterns. If any live entry cannot be corrected, the block writes nothing, raises `fail_o` and reports a count of zero.

Top module: `rs_err_apply`

## Requirements
- R1: After reset `busy_o`, `done_o` and `fail_o` are low, `count_o` is 0, and `mem_en_o` is low.
- R2: An odd position p changes byte floor(3p/2) by XOR with pattern bits 11:4, and byte floor(3p/2)+1 by XOR with pattern bits 3:0 placed in bits 7:4.
- R3: An even nonzero position p changes byte 3p/2-1 by XOR with pattern bits 11:8 placed in bits 3:0, and byte 3p/2 by XOR with pattern bits 7:0.
- R4: Position 0 changes only byte 0, by XOR with pattern bits 7:0. A pattern above 0xFF at position 0 is uncorrectable.
- R5: The spare area starts at linear address DATA_BYTES (2048). Position 1365 therefore changes data byte 2047 and spare byte 0, and higher positions land in the spare area by the same odd/even rule.
- R6: Positions up to LAST_POS (1374) are accepted. Any live position above LAST_POS is uncorrectable.
- R7: Each touched byte takes one read cycle followed by one write cycle to the same address. `done_o` is high exactly 1+2B cycles after the start edge, where B is the number of touched bytes.
- R8: Entries are applied in index order, each finishing before the next begins. A byte touched by several symbols receives all of their masks.
- R9: Uncorrectability is decided at start over the live entries. A `num_i` above MAX_ERR is also uncorrectable. An uncorrectable request makes no RAM writes, pulses `done_o` one cycle after start, sets `fail_o` and reports a count of 0.
- R10: A correctable request ends with a one-cycle `done_o`, `fail_o` low and `count_o` equal to `num_i`. A request with `num_i` of 0 finishes one cycle after start with no RAM access.
- R11: Entries at index `num_i` and above are ignored, even when they hold invalid positions or patterns.
- R12: `start_i` is ignored while `busy_o` is high. Positions and patterns are captured at the start edge.
- R13: `fail_o` and `count_o` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, accepted when idle |
| num_i | input | CNT_W | Number of live entries |
| pos_i | input | MAX_ERR*POS_W | Packed symbol positions, entry i at bits i*POS_W |
| pat_i | input | MAX_ERR*12 | Packed 12-bit error values, entry i at bits i*12 |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Last request was uncorrectable |
| count_o | output | CNT_W | Patterns applied by the last request |
| mem_en_o | output | 1 | RAM access enable |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | ADDR_W | RAM byte address |
| mem_wdata_o | output | 8 | RAM write data |
| mem_rdata_i | input | 8 | RAM read data, valid one cycle after a read |

## Verification
The bench builds the block with its defaults: 2048 data bytes, 64 spare bytes, LAST_POS 1374 and four entries with a 3-bit count. These values put the straddling symbol 1365, the last spare position 1374 and its rejected neighbour 1375 within reach. Because the count field is wider than the entry limit, an over-range count of 5 can also be driven. The bench models the RAM as an array and keeps a separately computed expected image. It checks the busy and done timeline on every clock, and compares the whole buffer after each request.

// File: rtl/rs_apply_pkg.sv
package rs_apply_pkg;
  localparam int SYM_W  = 12;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_FIN} app_state_e;
endpackage

// File: rtl/rs_apply_screen.sv
module rs_apply_screen import rs_apply_pkg::*; #(
  parameter int MAX_ERR  = 4,
  parameter int POS_W    = 12,
  parameter int CNT_W    = 3,
  parameter int LAST_POS = 1374
) (
  input  logic [CNT_W-1:0]         num_i,
  input  logic [MAX_ERR*POS_W-1:0] pos_i,
  input  logic [MAX_ERR*SYM_W-1:0] pat_i,
  output logic                     bad_o
);
  logic [MAX_ERR-1:0] bad_e;

  for (genvar gi = 0; gi < MAX_ERR; gi++) begin : g_ent
    logic [POS_W-1:0] p;
    logic [SYM_W-1:0] v;
    assign p = pos_i[gi*POS_W +: POS_W];
    assign v = pat_i[gi*SYM_W +: SYM_W];
    // only live entries count
    assign bad_e[gi] = (CNT_W'(gi) < num_i) &&
                       ((p > POS_W'(LAST_POS)) || ((p == '0) && (|v[SYM_W-1:BYTE_W])));
  end

  assign bad_o = (|bad_e) || (num_i > CNT_W'(MAX_ERR));
endmodule

// File: rtl/rs_apply_map.sv
module rs_apply_map import rs_apply_pkg::*; #(
  parameter int POS_W  = 12,
  parameter int ADDR_W = 12
) (
  input  logic [POS_W-1:0]  pos_i,
  input  logic [SYM_W-1:0]  pat_i,
  output logic [ADDR_W-1:0] addr0_o,
  output logic [BYTE_W-1:0] mask0_o,
  output logic [BYTE_W-1:0] mask1_o,
  output logic              pair_o
);
  logic [POS_W:0] span;  // floor(3p/2)
  assign span = {1'b0, pos_i} + {2'b0, pos_i[POS_W-1:1]};

  always_comb begin
    addr0_o = '0;
    mask0_o = pat_i[7:0];
    mask1_o = '0;
    pair_o  = 1'b0;
    if (pos_i == '0) begin
      pair_o = 1'b0;
    end else if (pos_i[0]) begin
      addr0_o = ADDR_W'(span);
      mask0_o = pat_i[11:4];
      mask1_o = {pat_i[3:0], 4'h0};
      pair_o  = 1'b1;
    end else begin
      addr0_o = ADDR_W'(span - (POS_W+1)'(1));
      mask0_o = {4'h0, pat_i[11:8]};
      mask1_o = pat_i[7:0];
      pair_o  = 1'b1;
    end
  end
endmodule

// File: rtl/rs_err_apply.sv
module rs_err_apply import rs_apply_pkg::*; #(
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int LAST_POS    = 1374,
  parameter int MAX_ERR     = 4,
  parameter int POS_W       = 12,
  parameter int ADDR_W      = $clog2(DATA_BYTES + SPARE_BYTES),
  parameter int CNT_W       = $clog2(MAX_ERR + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [CNT_W-1:0]         num_i,
  input  logic [MAX_ERR*POS_W-1:0] pos_i,
  input  logic [MAX_ERR*SYM_W-1:0] pat_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     fail_o,
  output logic [CNT_W-1:0]         count_o,
  output logic                     mem_en_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic [BYTE_W-1:0]        mem_wdata_o,
  input  logic [BYTE_W-1:0]        mem_rdata_i
);
  localparam int IDX_W = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;

  app_state_e               state_q;
  logic [MAX_ERR*POS_W-1:0] pos_q;
  logic [MAX_ERR*SYM_W-1:0] pat_q;
  logic [CNT_W-1:0]         num_q;
  logic [IDX_W-1:0]         idx_q;
  logic                     hi_q;
  logic                     fail_q;
  logic [CNT_W-1:0]         count_q;

  logic              bad;
  logic [POS_W-1:0]  cur_pos;
  logic [SYM_W-1:0]  cur_pat;
  logic [ADDR_W-1:0] addr0;
  logic [BYTE_W-1:0] mask0, mask1;
  logic              pair;
  logic              last_ent;

  rs_apply_screen #(
    .MAX_ERR(MAX_ERR), .POS_W(POS_W), .CNT_W(CNT_W), .LAST_POS(LAST_POS)
  ) u_screen (
    .num_i(num_i), .pos_i(pos_i), .pat_i(pat_i), .bad_o(bad)
  );

  assign cur_pos = pos_q[idx_q*POS_W +: POS_W];
  assign cur_pat = pat_q[idx_q*SYM_W +: SYM_W];

  rs_apply_map #(.POS_W(POS_W), .ADDR_W(ADDR_W)) u_map (
    .pos_i(cur_pos), .pat_i(cur_pat),
    .addr0_o(addr0), .mask0_o(mask0), .mask1_o(mask1), .pair_o(pair)
  );

  assign last_ent = (CNT_W'(idx_q) + CNT_W'(1)) == num_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      pat_q   <= '0;
      num_q   <= '0;
      idx_q   <= '0;
      hi_q    <= 1'b0;
      fail_q  <= 1'b0;
      count_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          pos_q   <= pos_i;
          pat_q   <= pat_i;
          num_q   <= num_i;
          idx_q   <= '0;
          hi_q    <= 1'b0;
          fail_q  <= bad;
          count_q <= bad ? '0 : num_i;
          state_q <= (bad || num_i == '0) ? ST_FIN : ST_RD;
        end
        ST_RD: state_q <= ST_WR;
        ST_WR: begin
          if (!hi_q && pair) begin
            hi_q    <= 1'b1;
            state_q <= ST_RD;
          end else begin
            hi_q <= 1'b0;
            if (last_ent) state_q <= ST_FIN;
            else begin
              idx_q   <= idx_q + IDX_W'(1);
              state_q <= ST_RD;
            end
          end
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = state_q != ST_IDLE;
  assign done_o      = state_q == ST_FIN;
  assign fail_o      = fail_q;
  assign count_o     = count_q;
  assign mem_en_o    = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o    = state_q == ST_WR;
  assign mem_addr_o  = addr0 + ADDR_W'(hi_q);
  assign mem_wdata_o = mem_rdata_i ^ (hi_q ? mask1 : mask0);
endmodule

// File: rtl/rs_err_apply_chk.sv
module rs_err_apply_chk #(
  parameter int TOTAL_BYTES = 2112,
  parameter int MAX_ERR     = 4,
  parameter int ADDR_W      = 12,
  parameter int CNT_W       = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic              fail_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  assert_rmw_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($past(mem_en_o) && !$past(mem_we_o) && mem_addr_o == $past(mem_addr_o)));

  assert_addr_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> (mem_addr_o < ADDR_W'(TOTAL_BYTES)));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_fail_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> !mem_we_o);

  assert_count_limit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (count_o <= CNT_W'(MAX_ERR)));

  assert_fail_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fail_o) |-> (count_o == '0));
endmodule

bind rs_err_apply rs_err_apply_chk #(
  .TOTAL_BYTES(DATA_BYTES + SPARE_BYTES), .MAX_ERR(MAX_ERR),
  .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .fail_o(fail_o),
  .count_o(count_o), .mem_en_o(mem_en_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o)
);

// File: tb/tb_rs_err_apply.sv
module tb_rs_err_apply;
  localparam int DATA_BYTES = 2048, SPARE_BYTES = 64, LAST_POS = 1374;
  localparam int MAX_ERR = 4, POS_W = 12, SYM_W = 12;
  localparam int TOTAL = DATA_BYTES + SPARE_BYTES;
  localparam int ADDR_W = 12, CNT_W = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [CNT_W-1:0] num_i = '0;
  logic [MAX_ERR*POS_W-1:0] pos_i = '0;
  logic [MAX_ERR*SYM_W-1:0] pat_i = '0;
  logic busy_o, done_o, fail_o, mem_en_o, mem_we_o;
  logic [CNT_W-1:0] count_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [7:0] mem_wdata_o, mem_rdata_i;

  rs_err_apply #(.DATA_BYTES(DATA_BYTES), .SPARE_BYTES(SPARE_BYTES), .LAST_POS(LAST_POS),
    .MAX_ERR(MAX_ERR), .POS_W(POS_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .num_i(num_i), .pos_i(pos_i),
    .pat_i(pat_i), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .count_o(count_o),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i));

  always #10 clk_i = ~clk_i;

  logic [7:0] ram [TOTAL];
  logic [7:0] expv [TOTAL];
  int total = 0, bad = 0, wr_cnt = 0;
  int tp [MAX_ERR];
  int tq [MAX_ERR];

  always @(posedge clk_i) begin
    if (mem_en_o) begin
      if (mem_we_o) begin
        ram[mem_addr_o] <= mem_wdata_o;
        wr_cnt <= wr_cnt + 1;
      end
      mem_rdata_i <= ram[mem_addr_o];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected image update, written in data/spare terms
  task automatic ref_apply(input int p, input int q);
    if (p == 0) expv[0] ^= 8'(q);
    else if (p == 1365) begin
      expv[2047] ^= 8'(q >> 4);
      expv[DATA_BYTES + 0] ^= 8'(q << 4);
    end else if (p > 1365) begin
      if (p % 2 == 1) begin
        expv[DATA_BYTES + 3*p/2 - 2048] ^= 8'(q >> 4);
        expv[DATA_BYTES + 3*p/2 - 2047] ^= 8'(q << 4);
      end else begin
        expv[DATA_BYTES + 3*p/2 - 2049] ^= 8'(q >> 8);
        expv[DATA_BYTES + 3*p/2 - 2048] ^= 8'(q);
      end
    end else if (p % 2 == 1) begin
      expv[3*p/2] ^= 8'(q >> 4);
      expv[3*p/2 + 1] ^= 8'(q << 4);
    end else begin
      expv[3*p/2 - 1] ^= 8'(q >> 8);
      expv[3*p/2] ^= 8'(q);
    end
  endtask

  task automatic set_e(input int i, input int p, input int q);
    tp[i] = p; tq[i] = q;
  endtask

  task automatic run(input int num, input bit poke, input string req);
    bit efail;
    int nb, elen, w0, mism, first;
    efail = (num > MAX_ERR);
    nb = 0;
    for (int i = 0; i < MAX_ERR; i++) if (i < num) begin
      if (tp[i] > LAST_POS || (tp[i] == 0 && tq[i] > 255)) efail = 1;
      nb += (tp[i] == 0) ? 1 : 2;
    end
    elen = efail ? 1 : 1 + 2*nb;
    w0 = wr_cnt;
    @(negedge clk_i);
    start_i = 1'b1;
    num_i = CNT_W'(num);
    for (int i = 0; i < MAX_ERR; i++) begin
      pos_i[i*POS_W +: POS_W] = POS_W'(tp[i]);
      pat_i[i*SYM_W +: SYM_W] = SYM_W'(tq[i]);
    end
    for (int k = 1; k <= elen; k++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (poke && k == 2) begin
        // R12: request while busy, different data
        start_i = 1'b1;
        num_i = CNT_W'(1);
        pos_i = '0;
        pos_i[POS_W-1:0] = POS_W'(7);
        pat_i = '1;
      end
      check(busy_o == 1'b1, {req, " busy R7"}, busy_o, 1);
      check(done_o == (k == elen), {req, " done timing R7"}, done_o, (k == elen));
    end
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b0 && done_o == 1'b0, {req, " idle after done R10"}, busy_o, 0);
    check(fail_o == efail, {req, " fail flag R9 R13"}, fail_o, efail);
    check(count_o == CNT_W'(efail ? 0 : num), {req, " count R10 R13"}, count_o, efail ? 0 : num);
    check(wr_cnt - w0 == (efail ? 0 : nb), {req, " writes R7 R9"}, wr_cnt - w0, efail ? 0 : nb);
    if (!efail) for (int i = 0; i < num; i++) ref_apply(tp[i], tq[i]);
    mism = 0; first = -1;
    for (int a = 0; a < TOTAL; a++) if (ram[a] !== expv[a]) begin
      mism++;
      if (first < 0) first = a;
    end
    if (mism != 0) $display("FAIL %s first mismatch at %0d: actual=%0d expected=%0d",
                            req, first, ram[first], expv[first]);
    total++;
    if (mism != 0) bad++;
  endtask

  initial begin
    for (int a = 0; a < TOTAL; a++) begin
      ram[a] = 8'(a*7 + 3);
      expv[a] = 8'(a*7 + 3);
    end
    for (int i = 0; i < MAX_ERR; i++) set_e(i, 0, 0);
    repeat (3) @(negedge clk_i);
    check(busy_o == 0 && done_o == 0 && fail_o == 0, "R1 reset flags", busy_o, 0);
    check(count_o == 0 && mem_en_o == 0, "R1 reset count/ram", count_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(busy_o == 0 && mem_en_o == 0, "R1 idle after reset", busy_o, 0);

    set_e(0, 1, 'hABC);     run(1, 0, "R2 odd");
    set_e(0, 2, 'h5A3);     run(1, 0, "R3 even");
    set_e(0, 0, 'h0FF);     run(1, 0, "R4 zero ok");
    set_e(0, 0, 'h100);     run(1, 0, "R4 zero wide");
    set_e(0, 1365, 'h9E7);  run(1, 0, "R5 boundary");
    set_e(0, 1374, 'h321);  run(1, 0, "R6 last");
    set_e(0, 1375, 'h001);  run(1, 0, "R6 beyond");
    set_e(0, 1, 'h111); set_e(1, 2, 'h222); set_e(2, 1366, 'h5AF); set_e(3, 3, 'hF0F);
    run(4, 0, "R8 four shared");
    run(0, 0, "R10 zero count");
    set_e(0, 4, 'h1); set_e(1, 6, 'h2); set_e(2, 8, 'h3); set_e(3, 10, 'h4);
    run(5, 0, "R9 count over");
    set_e(0, 7, 'h1); set_e(1, 9, 'h2); set_e(2, 11, 'h3); set_e(3, 2000, 'h4);
    run(4, 0, "R9 late bad entry");
    set_e(0, 10, 'h0AA); set_e(1, 4000, 'hFFF); set_e(2, 0, 'hFFF); set_e(3, 3000, 'h1);
    run(1, 0, "R11 dead entries");
    set_e(0, 20, 'h123); set_e(1, 21, 'h456);
    run(2, 1, "R12 start while busy");
    set_e(0, 5, 'h0F0); set_e(1, 5, 'h0F0);
    run(2, 0, "R8 repeated position");
    set_e(0, 1367, 'hC3D); set_e(1, 1368, 'h7E1);
    run(2, 0, "R5 spare odd/even");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule